// File: doc/BRIEF.md
# Programmable Serial Clock Prescaler

This block derives the serial clock of a flash interface from the system bus clock. An 8-bit divide code `div_i` selects a division factor of `div_i + 1`, so factors from 1 to 256 are available. A code of zero does not divide at all: the bus clock itself is gated through to the output. Every output period begins with its high phase. A one-cycle strobe marks each rising output edge so that downstream shift logic can act on it without sampling the generated clock.

The clock runs only while the interface is enabled (`en_i`) and a transfer is in progress (`busy_i`). The divide code is copied into a shadow register on each bus clock edge at which `busy_i` is low. While `busy_i` is high the shadow holds its value, so writes to the code during a transfer cannot disturb the running clock. Changing between bypass and divided operation therefore takes place only while the output is stopped and low. A running period always starts from the beginning of its high phase, so no truncated pulse appears when the mode changes.

Top module: `sclk_prescaler`

## Requirements
- R1: While running with code D ≥ 1, rising-edge strobes on `rise_o` are spaced exactly D+1 bus clock cycles apart.
- R2: While running with code 0, `sclk_o` follows the bus clock: it is high in every high phase and low in every low phase, and `rise_o` is high in every such cycle. The first pulse appears one bus cycle after the edge that starts the run.
- R3: For an odd factor N = D+1, `sclk_o` is high for (N+1)/2 bus cycles and low for (N-1)/2 bus cycles in each period.
- R4: For an even factor N = D+1, `sclk_o` is high for N/2 bus cycles and low for N/2 bus cycles.
- R5: `div_i` is captured into the active setting at every bus clock edge where `busy_i` is 0. Changes to `div_i` while `busy_i` is 1 have no effect on `sclk_o` or `rise_o`.
- R6: When `en_i` or `busy_i` is 0 at a bus clock edge, `sclk_o` and `rise_o` are low after that edge. In bypass mode this takes effect after the following edge, once the last pulse has completed.
- R7: In divided mode, on the first edge at which the clock runs, `sclk_o` goes high and `rise_o` goes high in the same cycle.
- R8: In divided mode, `rise_o` is high for exactly the one bus cycle in which `sclk_o` has risen, and never while `sclk_o` is low.
- R9: While `rst` is high, `sclk_o` and `rise_o` are low.
- R10: Code 255 gives a factor of 256, with 128 cycles high and 128 cycles low.
- R11: A change between bypass and divided operation happens only while the output is stopped. The divided output is never high while the bypass setting is active, and the active setting never changes while the clock keeps running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System bus clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Interface enable |
| busy_i | input | 1 | Transfer in progress; freezes the divide setting and lets the clock run |
| div_i | input | 8 | Divide code; factor = code + 1, 0 = bypass |
| sclk_o | output | 1 | Generated serial clock |
| rise_o | output | 1 | One-cycle strobe in the bus cycle where `sclk_o` rises |

## Verification
The bench compares both phases of every bus cycle against a behavioural model. It targets factors 2, 3, 5, 6 and 256 for the duty split. A design that rounds the wrong way would put the extra odd-factor cycle into the low phase, or would lose a cycle at the wrap. Bypass runs check that the gated clock appears one cycle after the start and stops cleanly. The bench changes the code in the middle of a transfer: a design that leaks the write would show a changed period at once. Back-to-back changes between bypass and divided operation, separated by a single idle cycle, would expose a design that lets both output paths drive a pulse at the changeover.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  localparam int unsigned SCLK_DIV_W = 8;

  typedef enum logic [1:0] {
    SCLK_IDLE   = 2'd0,
    SCLK_BYPASS = 2'd1,
    SCLK_DIVIDE = 2'd2
  } sclk_mode_e;
endpackage

// File: rtl/sclk_div_shadow.sv
module sclk_div_shadow #(
  parameter int unsigned DIV_W = sclk_pkg::SCLK_DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] div_q,
  output logic             byp_o
);
  // Setting follows the request only while no transfer is in flight.
  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
    end else if (!busy_i) begin
      div_q <= div_i;
    end
  end

  assign byp_o = (div_q == '0);
endmodule

// File: rtl/sclk_div_core.sv
module sclk_div_core #(
  parameter int unsigned DIV_W = sclk_pkg::SCLK_DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             rise_o
);
  localparam int unsigned HW = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] idx_nxt;
  logic             act_q;
  logic [HW-1:0]    hi_len;

  // High phase lasts ceil((div+1)/2) cycles.
  always_comb begin
    hi_len = ({1'b0, div_i} + HW'(2)) >> 1;
    if (!act_q || (cnt_q == div_i)) begin
      idx_nxt = '0;
    end else begin
      idx_nxt = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q  <= '0;
      act_q  <= 1'b0;
      sclk_o <= 1'b0;
      rise_o <= 1'b0;
    end else begin
      cnt_q  <= idx_nxt;
      act_q  <= 1'b1;
      sclk_o <= ({1'b0, idx_nxt} < hi_len);
      rise_o <= (idx_nxt == '0);
    end
  end

  p_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (!sclk_o && !rise_o));
  p_start_high_r7: assert property (@(posedge clk) disable iff (rst)
    (run_i && !act_q) |=> (sclk_o && rise_o));
  p_strobe_high_r8: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> sclk_o);
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
    act_q |-> (cnt_q <= div_i));
endmodule

// File: rtl/sclk_bypass_gate.sv
module sclk_bypass_gate (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic gclk_o,
  output logic rise_o
);
  logic brun_q;
  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      brun_q <= 1'b0;
      rise_o <= 1'b0;
    end else begin
      brun_q <= run_i;
      rise_o <= brun_q;
    end
  end

  // Enable changes only while clk is low, so gated pulses are always whole.
  always_ff @(negedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
    end else begin
      gate_q <= brun_q;
    end
  end

  assign gclk_o = clk & gate_q;
endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler #(
  parameter int unsigned DIV_W = sclk_pkg::SCLK_DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             busy_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             rise_o
);
  import sclk_pkg::*;

  logic [DIV_W-1:0] div_act;
  logic             byp;
  logic             run;
  sclk_mode_e       mode;
  logic             d_sclk, d_rise;
  logic             b_gclk, b_rise;

  assign run = en_i & busy_i;

  always_comb begin
    if (!run)     mode = SCLK_IDLE;
    else if (byp) mode = SCLK_BYPASS;
    else          mode = SCLK_DIVIDE;
  end

  sclk_div_shadow #(.DIV_W(DIV_W)) u_shadow (
    .clk    (clk),
    .rst    (rst),
    .busy_i (busy_i),
    .div_i  (div_i),
    .div_q  (div_act),
    .byp_o  (byp)
  );

  sclk_div_core #(.DIV_W(DIV_W)) u_core (
    .clk    (clk),
    .rst    (rst),
    .run_i  (mode == SCLK_DIVIDE),
    .div_i  (div_act),
    .sclk_o (d_sclk),
    .rise_o (d_rise)
  );

  sclk_bypass_gate u_gate (
    .clk    (clk),
    .rst    (rst),
    .run_i  (mode == SCLK_BYPASS),
    .gclk_o (b_gclk),
    .rise_o (b_rise)
  );

  // Paths are never active together, so an OR merges them glitch-free.
  assign sclk_o = d_sclk | b_gclk;
  assign rise_o = d_rise | b_rise;

  p_setting_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> $stable(div_act));
  p_paths_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
    byp |-> !d_sclk);
  p_no_dual_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    !(d_rise && b_rise));
endmodule

// File: tb/sclk_prescaler_tb.sv
module sclk_prescaler_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_i = 1'b0;
  logic       busy_i = 1'b0;
  logic [7:0] div_i = 8'd0;
  logic       sclk_o, rise_o;

  int    n_run = 0;
  int    n_fail = 0;
  string tag_ovr = "";
  bit    checking = 1'b0;

  always #10 clk = ~clk;

  sclk_prescaler u_dut (
    .clk(clk), .rst(rst), .en_i(en_i), .busy_i(busy_i),
    .div_i(div_i), .sclk_o(sclk_o), .rise_o(rise_o)
  );

  // Behavioural reference model
  int    m_div = 0, m_idx = 0;
  bit    m_act = 0, m_brun = 0, m_first = 0;
  bit    e_hi = 0, e_lo = 0, e_rise = 0, e_byp = 0;
  string m_tag = "R9";

  always @(posedge clk) begin
    bit run, byp_hi, dh, dr;
    int n;
    if (rst) begin
      m_div = 0; m_idx = 0; m_act = 0; m_brun = 0; m_first = 0;
      e_hi = 0; e_lo = 0; e_rise = 0; e_byp = 0; m_tag = "R9";
    end else begin
      run    = en_i && busy_i;
      n      = m_div + 1;
      byp_hi = m_brun;
      m_brun = run && (m_div == 0);
      m_first = 0;
      if (run && m_div != 0) begin
        m_first = !m_act;
        m_idx   = m_act ? (m_idx + 1) % n : 0;
        m_act   = 1;
        dh      = (m_idx < (n + 1) / 2);
        dr      = (m_idx == 0);
      end else begin
        m_act = 0; dh = 0; dr = 0;
      end
      e_hi = byp_hi || dh; e_lo = dh; e_rise = byp_hi || dr; e_byp = byp_hi;
      if (byp_hi)          m_tag = "R2";
      else if (m_first)    m_tag = "R7";
      else if (!m_act)     m_tag = "R6";
      else if (n % 2 == 1) m_tag = "R3";
      else                 m_tag = "R4";
      if (!busy_i) m_div = int'(div_i);
    end
  end

  task automatic chk(input logic act, input logic exp, input string tg, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tg, what, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // Compare in the middle of each phase, away from both clock edges
  int cyc = 0, last_rise = 0;
  bit rise_valid = 0;
  initial begin
    forever begin
      string tg;
      @(posedge clk);
      cyc++;
      #5;
      if (checking) begin
        tg = (tag_ovr != "") ? tag_ovr : m_tag;
        chk(sclk_o, e_hi, tg, "sclk high phase");
        chk(rise_o, e_rise, e_byp ? "R2" : (tag_ovr != "" ? tag_ovr : "R8"), "rise strobe");
        if (m_act && m_div != 0) begin
          if (rise_o === 1'b1) begin
            if (rise_valid) begin
              n_run++;
              if (cyc - last_rise != m_div + 1) begin
                n_fail++;
                $display("FAIL R1 period: actual %0d expected %0d", cyc - last_rise, m_div + 1);
              end
            end
            rise_valid = 1; last_rise = cyc;
          end
        end else begin
          rise_valid = 0;
        end
        #10;
        chk(sclk_o, e_lo, tg, "sclk low phase");
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #12;
  endtask

  task automatic run_div(input int d, input int cycles, input string tg);
    wait_cyc(1);
    tag_ovr = tg; busy_i = 0; div_i = 8'(d); en_i = 1;
    wait_cyc(1);
    busy_i = 1;
    wait_cyc(cycles);
    busy_i = 0;
    wait_cyc(3);
    tag_ovr = "";
  endtask

  initial begin
    wait_cyc(1);
    checking = 1;
    wait_cyc(3);
    chk(sclk_o, 1'b0, "R9", "reset sclk");
    chk(rise_o, 1'b0, "R9", "reset strobe");
    rst = 0;
    wait_cyc(3);                       // idle: R6
    run_div(1, 8, "");                 // N=2, R4
    run_div(2, 9, "");                 // N=3, R3
    run_div(4, 12, "");                // N=5, R3
    run_div(5, 14, "");                // N=6, R4
    run_div(0, 6, "");                 // bypass, R2
    run_div(255, 600, "R10");          // N=256
    // R5: writes during busy ignored
    tag_ovr = "R5"; busy_i = 0; div_i = 8'd3; en_i = 1;
    wait_cyc(1); busy_i = 1;
    wait_cyc(5); div_i = 8'd0;
    wait_cyc(5); div_i = 8'd7;
    wait_cyc(6); busy_i = 0;
    wait_cyc(3);
    // R6: enable dropped while busy
    tag_ovr = ""; div_i = 8'd2;
    wait_cyc(1); busy_i = 1;
    wait_cyc(7); en_i = 0; tag_ovr = "R6";
    wait_cyc(4); en_i = 1; tag_ovr = "";
    wait_cyc(6); busy_i = 0;
    wait_cyc(3);
    // R11: bypass -> divided -> bypass with single idle cycles
    tag_ovr = "R11"; div_i = 8'd0;
    wait_cyc(1); busy_i = 1;
    wait_cyc(5); busy_i = 0; div_i = 8'd3;
    wait_cyc(1); busy_i = 1;
    wait_cyc(10); busy_i = 0; div_i = 8'd0;
    wait_cyc(1); busy_i = 1;
    wait_cyc(5); busy_i = 0;
    wait_cyc(4);
    report();
  end
endmodule